// File: doc/BRIEF.md
# Two-Stage Guest Protection Fault Resolver

This block settles the outcome of a memory access that may be checked by two protection stages. One stage is owned by the guest supervisor. The other is owned by the hypervisor. Both stages receive precomputed per-entry match vectors, each entry's address-mode enable bit and a 4-bit permission field per entry. The block returns whether the access may proceed. When it may not, the block also returns a 6-bit exception cause and a one-bit flag that names the privilege level which handles the trap.

With virtualization off, only the hypervisor stage is used, and it acts as an ordinary supervisor protection check. With virtualization on, the guest stage is logically applied first and the hypervisor stage second. The two are evaluated side by side, and the combined answer is the same as the sequential one. Which stage refused the access selects between the ordinary page-fault codes and the guest-page-fault codes. A permission pattern that is reserved for shadow stacks always refuses guest traffic in the hypervisor stage.

The result sits in a register. It appears one clock after the inputs are sampled, so the resolver can be placed between the match logic and the trap logic without adding to either path.

Top module: `gtrap_resolver`

## Requirements
- R1: While `rstN` is low, `allowOut`, `causeOut` and `toHyp` are all 0. After reset, the outputs present the decision for the inputs sampled at the previous rising edge of `clk`.
- R2: The access type is encoded on `accType` as follows: 0 is a fetch and needs X, 1 is a load and needs R, and 2 or 3 is a store/AMO and needs W. Entry i's permission field sits at bits [4i+3:4i] of its stage's config vector, laid out as bit 0 = R, bit 1 = W, bit 2 = X and bit 3 = SHARED.
- R3: Within a stage, the lowest-indexed entry that both matches and is active decides the permission. Higher-indexed hits are ignored.
- R4: With `virtOn`=0, only the hypervisor stage counts, and a hypervisor entry is active when both `hostActive[i]` and `hostSwitch[i]` are set. The guest inputs and `guestSwitch` have no effect. If no entry hits, the access is allowed. A denial gives cause 12 for a fetch, 13 for a load and 15 for a store/AMO, with `toHyp`=1.
- R5: With `virtOn`=1, a hypervisor entry is active only when both `hostActive[i]` and `guestSwitch[i]` are set. `hostSwitch` has no effect.
- R6: With `virtOn`=1, the access is allowed only when both stages permit it.
- R7: With `virtOn`=1, a guest-stage denial gives `toHyp`=0 and cause 12, 13 or 15 for fetch, load or store/AMO. This holds whatever the hypervisor stage decides.
- R8: With `virtOn`=1, a denial by the hypervisor stage alone gives `toHyp`=1 and cause 20, 21 or 23 for fetch, load or store/AMO.
- R9: With `virtOn`=1, a deciding hypervisor entry whose field reads R=0, W=1, X=0, SHARED=1 denies every access type. With `virtOn`=0, the same entry grants exactly what its R/W/X bits say.
- R10: With `virtOn`=1, a stage in which no entry hits denies the access.
- R11: An allowed access reports `causeOut`=0 and `toHyp`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| virtOn | input | 1 | Access comes from a guest (virtualization on) |
| accType | input | 2 | 0 fetch, 1 load, 2/3 store or AMO |
| guestMatch | input | N | Guest-stage per-entry address match |
| guestActive | input | N | Guest-stage per-entry address-mode enable |
| guestCfg | input | 4*N | Guest-stage permission fields {SHARED,X,W,R} per entry |
| hostMatch | input | N | Hypervisor-stage per-entry address match |
| hostActive | input | N | Hypervisor-stage per-entry address-mode enable |
| hostCfg | input | 4*N | Hypervisor-stage permission fields {SHARED,X,W,R} per entry |
| hostSwitch | input | N | Entry-enable mask used when virtualization is off |
| guestSwitch | input | N | Entry-enable mask used when virtualization is on |
| allowOut | output | 1 | Access permitted |
| causeOut | output | 6 | Exception cause code, 0 when allowed |
| toHyp | output | 1 | Trap target: 0 guest supervisor, 1 hypervisor |

## Verification
Four behaviours are checked on every cycle. An allowed access must carry a clean cause. Under virtualization, the code family must agree with the trap target. A fetch may only fault with a fetch code. When a stage has no hit, the expected result follows: a miss is allowed with virtualization off, and denied with virtualization on. Only the bench's scenarios can show the rest, because each needs the contents of the permission fields. These are the lowest-index priority, the reserved shadow-stack pattern, and the way the two switch masks trade places. The bench also sweeps random inputs against a behavioural model.

// File: rtl/gtrap_pkg.sv
package gtrap_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_AMO   = 2'd3
  } acc_e;

  // Per-entry permission field layout
  localparam int CFG_W     = 4;
  localparam int CFG_R_BIT = 0;
  localparam int CFG_W_BIT = 1;
  localparam int CFG_X_BIT = 2;
  localparam int CFG_S_BIT = 3;

  localparam int CAUSE_W = 6;
  // Guest-level fault codes; hypervisor-level codes sit GUEST_OFFSET above
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 6'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 6'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 6'd15;
  localparam logic [CAUSE_W-1:0] GUEST_OFFSET = 6'd8;

  // Strobes from control to datapath
  typedef struct packed {
    logic virt;
    logic needR;
    logic needW;
    logic needX;
  } evalStrobes_t;

  // Verdicts from datapath back to control
  typedef struct packed {
    logic guestPermit;
    logic hostPermit;
  } stageVerdict_t;

endpackage

// File: rtl/gtrap_stage.sv
module gtrap_stage
  import gtrap_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]       matchVec,
  input  logic [N-1:0]       activeVec,
  input  logic [CFG_W*N-1:0] cfgVec,
  input  evalStrobes_t       strobes,
  input  logic               rejectShadow,
  input  logic               denyOnMiss,
  output logic               permit
);

  logic [N-1:0] hitVec;
  logic [N-1:0] grantVec;

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic [CFG_W-1:0] fieldBits;
    logic rwGrant;
    logic reservedPat;
    assign fieldBits   = cfgVec[CFG_W*i +: CFG_W];
    assign hitVec[i]   = matchVec[i] & activeVec[i];
    assign rwGrant     = (strobes.needR & fieldBits[CFG_R_BIT])
                       | (strobes.needW & fieldBits[CFG_W_BIT])
                       | (strobes.needX & fieldBits[CFG_X_BIT]);
    assign reservedPat = fieldBits[CFG_S_BIT] & fieldBits[CFG_W_BIT]
                       & ~fieldBits[CFG_R_BIT] & ~fieldBits[CFG_X_BIT];
    assign grantVec[i] = rwGrant & ~(rejectShadow & reservedPat);
  end

  // Lowest-indexed hit decides
  always_comb begin
    logic found;
    found  = 1'b0;
    permit = ~denyOnMiss;
    for (int i = 0; i < N; i++) begin
      if (!found && hitVec[i]) begin
        found  = 1'b1;
        permit = grantVec[i];
      end
    end
  end

endmodule

// File: rtl/gtrap_datapath.sv
module gtrap_datapath
  import gtrap_pkg::*;
#(
  parameter int N = 8
) (
  input  evalStrobes_t       strobes,
  input  logic [N-1:0]       guestMatch,
  input  logic [N-1:0]       guestActive,
  input  logic [CFG_W*N-1:0] guestCfg,
  input  logic [N-1:0]       hostMatch,
  input  logic [N-1:0]       hostActive,
  input  logic [CFG_W*N-1:0] hostCfg,
  input  logic [N-1:0]       hostSwitch,
  input  logic [N-1:0]       guestSwitch,
  output stageVerdict_t      verdict
);

  logic [N-1:0] hostEnable;
  logic         guestRaw;
  logic         hostRaw;

  assign hostEnable = hostActive & (strobes.virt ? guestSwitch : hostSwitch);

  gtrap_stage #(.N(N)) u_guestStage (
    .matchVec    (guestMatch),
    .activeVec   (guestActive),
    .cfgVec      (guestCfg),
    .strobes     (strobes),
    .rejectShadow(1'b0),
    .denyOnMiss  (1'b1),
    .permit      (guestRaw)
  );

  gtrap_stage #(.N(N)) u_hostStage (
    .matchVec    (hostMatch),
    .activeVec   (hostEnable),
    .cfgVec      (hostCfg),
    .strobes     (strobes),
    .rejectShadow(strobes.virt),
    .denyOnMiss  (strobes.virt),
    .permit      (hostRaw)
  );

  // Guest stage only counts under virtualization
  assign verdict.guestPermit = guestRaw | ~strobes.virt;
  assign verdict.hostPermit  = hostRaw;

endmodule

// File: rtl/gtrap_ctrl.sv
module gtrap_ctrl
  import gtrap_pkg::*;
(
  input  logic               virtOn,
  input  logic [1:0]         accType,
  input  stageVerdict_t      verdict,
  output evalStrobes_t       strobes,
  output logic               allowNext,
  output logic [CAUSE_W-1:0] causeNext,
  output logic               toHypNext
);

  acc_e accKind;
  logic [CAUSE_W-1:0] baseCause;

  assign accKind = acc_e'(accType);

  always_comb begin
    strobes       = '0;
    strobes.virt  = virtOn;
    unique case (accKind)
      ACC_FETCH: begin strobes.needX = 1'b1; baseCause = CAUSE_FETCH; end
      ACC_LOAD:  begin strobes.needR = 1'b1; baseCause = CAUSE_LOAD;  end
      default:   begin strobes.needW = 1'b1; baseCause = CAUSE_STORE; end
    endcase
  end

  always_comb begin
    allowNext = verdict.guestPermit & verdict.hostPermit;
    causeNext = '0;
    toHypNext = 1'b0;
    if (!allowNext) begin
      if (!virtOn) begin
        causeNext = baseCause;
        toHypNext = 1'b1;
      end else if (!verdict.guestPermit) begin
        causeNext = baseCause;
        toHypNext = 1'b0;
      end else begin
        causeNext = baseCause + GUEST_OFFSET;
        toHypNext = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gtrap_resolver.sv
module gtrap_resolver
  import gtrap_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                virtOn,
  input  logic [1:0]          accType,
  input  logic [N-1:0]        guestMatch,
  input  logic [N-1:0]        guestActive,
  input  logic [4*N-1:0]      guestCfg,
  input  logic [N-1:0]        hostMatch,
  input  logic [N-1:0]        hostActive,
  input  logic [4*N-1:0]      hostCfg,
  input  logic [N-1:0]        hostSwitch,
  input  logic [N-1:0]        guestSwitch,
  output logic                allowOut,
  output logic [5:0]          causeOut,
  output logic                toHyp
);

  evalStrobes_t       strobes;
  stageVerdict_t      verdict;
  logic               allowNext;
  logic [CAUSE_W-1:0] causeNext;
  logic               toHypNext;

  gtrap_ctrl u_ctrl (
    .virtOn   (virtOn),
    .accType  (accType),
    .verdict  (verdict),
    .strobes  (strobes),
    .allowNext(allowNext),
    .causeNext(causeNext),
    .toHypNext(toHypNext)
  );

  gtrap_datapath #(.N(N)) u_datapath (
    .strobes    (strobes),
    .guestMatch (guestMatch),
    .guestActive(guestActive),
    .guestCfg   (guestCfg),
    .hostMatch  (hostMatch),
    .hostActive (hostActive),
    .hostCfg    (hostCfg),
    .hostSwitch (hostSwitch),
    .guestSwitch(guestSwitch),
    .verdict    (verdict)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allowOut <= 1'b0;
      causeOut <= '0;
      toHyp    <= 1'b0;
    end else begin
      allowOut <= allowNext;
      causeOut <= causeNext;
      toHyp    <= toHypNext;
    end
  end

endmodule

// File: rtl/gtrap_resolver_chk.sv
module gtrap_resolver_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         virtOn,
  input logic [1:0]   accType,
  input logic [N-1:0] guestMatch,
  input logic [N-1:0] guestActive,
  input logic [N-1:0] hostMatch,
  input logic [N-1:0] hostActive,
  input logic [N-1:0] hostSwitch,
  input logic [N-1:0] guestSwitch,
  input logic         allowOut,
  input logic [5:0]   causeOut,
  input logic         toHyp
);

  assert_clean_allow_R11: assert property (@(posedge clk) disable iff (!rstN)
    allowOut |-> (causeOut == 6'd0 && !toHyp));

  assert_host_miss_allows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!virtOn && ((hostMatch & hostActive & hostSwitch) == '0)) |=> allowOut);

  assert_plain_fault_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    !virtOn |=> (allowOut || toHyp));

  assert_guest_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    (virtOn && ((guestMatch & guestActive) == '0)) |=> (!allowOut && !toHyp));

  assert_host_miss_virt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (virtOn && ((hostMatch & hostActive & guestSwitch) == '0)) |=> !allowOut);

  assert_family_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    virtOn |=> (allowOut || (toHyp == (causeOut >= 6'd20))));

  assert_fetch_codes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accType == 2'd0) |=> (allowOut || causeOut == 6'd12 || causeOut == 6'd20));

endmodule

bind gtrap_resolver gtrap_resolver_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .virtOn     (virtOn),
  .accType    (accType),
  .guestMatch (guestMatch),
  .guestActive(guestActive),
  .hostMatch  (hostMatch),
  .hostActive (hostActive),
  .hostSwitch (hostSwitch),
  .guestSwitch(guestSwitch),
  .allowOut   (allowOut),
  .causeOut   (causeOut),
  .toHyp      (toHyp)
);

// File: tb/gtrap_resolver_tb.sv
module gtrap_resolver_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         virtOn = 1'b0;
  logic [1:0]   accType = 2'd0;
  logic [N-1:0] guestMatch = '0, guestActive = '0, hostMatch = '0, hostActive = '0;
  logic [N-1:0] hostSwitch = '0, guestSwitch = '0;
  logic [4*N-1:0] guestCfg = '0, hostCfg = '0;
  logic         allowOut;
  logic [5:0]   causeOut;
  logic         toHyp;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gtrap_resolver #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .virtOn(virtOn), .accType(accType),
    .guestMatch(guestMatch), .guestActive(guestActive), .guestCfg(guestCfg),
    .hostMatch(hostMatch), .hostActive(hostActive), .hostCfg(hostCfg),
    .hostSwitch(hostSwitch), .guestSwitch(guestSwitch),
    .allowOut(allowOut), .causeOut(causeOut), .toHyp(toHyp)
  );

  // One stage's verdict: first hit wins, miss gives !missDeny
  function automatic bit stageOk(input logic [N-1:0] m, input logic [N-1:0] en,
                                 input logic [4*N-1:0] cf, input int acc,
                                 input bit reserve, input bit missDeny);
    for (int i = 0; i < N; i++) begin
      if (m[i] && en[i]) begin
        bit r = cf[4*i], w = cf[4*i+1], x = cf[4*i+2], s = cf[4*i+3];
        if (reserve && !r && w && !x && s) return 0;
        if (acc == 0) return x;
        if (acc == 1) return r;
        return w;
      end
    end
    return !missDeny;
  endfunction

  task automatic expectNow(output bit ok, output int cause, output bit hyp);
    int acc = int'(accType);
    int base = (acc == 0) ? 12 : (acc == 1) ? 13 : 15;
    bit g = 1, h;
    logic [N-1:0] hEn = hostActive & (virtOn ? guestSwitch : hostSwitch);
    if (virtOn) g = stageOk(guestMatch, guestActive, guestCfg, acc, 0, 1);
    h = stageOk(hostMatch, hEn, hostCfg, acc, virtOn, virtOn);
    ok = g && h; cause = 0; hyp = 0;
    if (!ok) begin
      if (!virtOn)  begin cause = base;     hyp = 1; end
      else if (!g)  begin cause = base;     hyp = 0; end
      else          begin cause = base + 8; hyp = 1; end
    end
  endtask

  // Inputs already set (at negedge); latch on posedge, compare at next negedge
  task automatic step(input string req);
    bit eOk, eHyp; int eCause;
    expectNow(eOk, eCause, eHyp);
    @(posedge clk); @(negedge clk);
    compared++;
    if (allowOut !== eOk || int'(causeOut) != eCause || toHyp !== eHyp) begin
      mismatched++;
      $display("FAIL %s: got allow=%0b cause=%0d hyp=%0b, expected allow=%0b cause=%0d hyp=%0b",
               req, allowOut, causeOut, toHyp, eOk, eCause, eHyp);
    end
  endtask

  function automatic logic [3:0] fld(input bit r, input bit w, input bit x, input bit s);
    return {s, x, w, r};
  endfunction

  task automatic clearAll();
    virtOn = 0; accType = 0; guestMatch = '0; guestActive = '0; guestCfg = '0;
    hostMatch = '0; hostActive = '0; hostCfg = '0; hostSwitch = '0; guestSwitch = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang, expected completion");
    summary();
  end

  initial begin
    // R1: reset state with busy inputs
    virtOn = 1; accType = 2; hostMatch = '1; hostActive = '1; hostSwitch = '1;
    hostCfg = '1;
    repeat (3) @(negedge clk);
    compared++;
    if (allowOut !== 0 || causeOut !== 0 || toHyp !== 0) begin
      mismatched++;
      $display("FAIL R1: got allow=%0b cause=%0d hyp=%0b, expected all 0", allowOut, causeOut, toHyp);
    end
    rstN = 1;
    clearAll();
    step("R1");

    // R2: access type vs R/W/X bits, virt off
    hostMatch[0] = 1; hostActive[0] = 1; hostSwitch[0] = 1;
    hostCfg[3:0] = fld(1, 0, 0, 0);
    for (int a = 0; a < 4; a++) begin accType = a[1:0]; step("R2"); end
    hostCfg[3:0] = fld(0, 1, 1, 0);
    for (int a = 0; a < 4; a++) begin accType = a[1:0]; step("R2"); end

    // R3: lowest index decides
    clearAll(); accType = 1;
    hostMatch = 8'b0000_0110; hostActive = '1; hostSwitch = '1;
    hostCfg[7:4] = fld(0, 0, 0, 0); hostCfg[11:8] = fld(1, 0, 0, 0);
    step("R3");
    hostActive[1] = 0; step("R3");
    virtOn = 1; guestSwitch = '1; hostActive[1] = 1;
    guestMatch = 8'b1100_0000; guestActive = '1;
    guestCfg[27:24] = fld(1, 0, 0, 0); guestCfg[31:28] = fld(0, 0, 0, 0);
    step("R3");

    // R4: virt off ignores guest inputs and guestSwitch; miss allows
    clearAll(); accType = 0;
    guestMatch = '1; guestActive = '1; guestCfg = '0; guestSwitch = '1;
    step("R4");
    hostMatch[5] = 1; hostActive[5] = 1; hostCfg[23:20] = fld(1, 1, 0, 0);
    step("R4");
    hostSwitch[5] = 1; step("R4");

    // R5: mask swap under virt
    clearAll(); virtOn = 1; accType = 1;
    guestMatch[2] = 1; guestActive[2] = 1; guestCfg[11:8] = fld(1, 1, 1, 0);
    hostMatch[3] = 1; hostActive[3] = 1; hostCfg[15:12] = fld(1, 0, 0, 0);
    hostSwitch[3] = 0; guestSwitch[3] = 1; step("R5");
    hostSwitch[3] = 1; guestSwitch[3] = 0; step("R5");

    // R6/R7/R8 with each access type
    for (int a = 0; a < 3; a++) begin
      accType = a[1:0];
      guestSwitch[3] = 1;
      guestCfg[11:8] = fld(1, 1, 1, 0); hostCfg[15:12] = fld(1, 1, 1, 0); step("R6");
      guestCfg[11:8] = fld(0, 0, 0, 0); hostCfg[15:12] = fld(1, 1, 1, 0); step("R7");
      guestCfg[11:8] = fld(0, 0, 0, 0); hostCfg[15:12] = fld(0, 0, 0, 0); step("R7");
      guestCfg[11:8] = fld(1, 1, 1, 0); hostCfg[15:12] = fld(0, 0, 0, 0); step("R8");
    end

    // R9: reserved shadow-stack pattern
    hostCfg[15:12] = fld(0, 1, 0, 1);
    for (int a = 0; a < 4; a++) begin accType = a[1:0]; step("R9"); end
    virtOn = 0; hostSwitch[3] = 1;
    for (int a = 0; a < 4; a++) begin accType = a[1:0]; step("R9"); end

    // R10: miss in either stage under virt
    virtOn = 1; accType = 1; hostCfg[15:12] = fld(1, 1, 1, 0);
    guestActive = '0; step("R10");
    guestActive[2] = 1; hostMatch = '0; step("R10");

    // R11 and broad sweep: random patterns, all requirements mixed
    for (int k = 0; k < 400; k++) begin
      virtOn = $urandom_range(0, 1); accType = 2'($urandom_range(0, 3));
      guestMatch = N'($urandom); guestActive = N'($urandom); guestCfg = $urandom;
      hostMatch = N'($urandom); hostActive = N'($urandom); hostCfg = $urandom;
      hostSwitch = N'($urandom); guestSwitch = N'($urandom);
      if (k % 4 == 0) hostCfg = {N{fld(0, 1, 0, 1)}};
      step("R11");
    end

    summary();
  end

endmodule